// File: doc/BRIEF.md
# Core Test Wrapper Control Sequencer

This block is a single finite state machine placed at chip level that produces the dynamic control strobes for every test wrapper around the embedded cores. It is driven by a test clock, a mode-select line and an active-low test reset. These three inputs mean the same as they do on a boundary-scan test access port. Internally it walks the familiar sixteen-state boundary-scan controller graph. That graph has a reset state, an idle state, and two parallel branches, one for the data path and one for the instruction path. Each branch has its own select, capture, shift, first exit, pause, second exit and update states.

Instead of producing the classic access-port outputs, the decode turns each state into the six wrapper control signals. These are the forwarded wrapper clock, an active-low wrapper reset, an instruction-register select, and shift, capture and update enables. All wrapped cores share one instance of the block. The block carries no data stream, so it has no valid/ready handshake: every pin is a plain control level, and no back-pressure rules apply.

Top module: `wrapper_ctrl_fsm`

## Requirements
- R1: While test_rst_n is low, the machine is held in the reset state without waiting for a clock edge. During that time wrap_rst_n is 0 and wrap_ir_sel, wrap_shift_en, wrap_capture_en and wrap_update_en are all 0.
- R2: wrap_clk equals test_clk at all times, with no register in the path.
- R3: On each rising edge of test_clk, the state moves along the sixteen-state boundary-scan graph, and test_mode_sel chooses the branch. No state change happens at any other time.
- R4: Five consecutive rising edges with test_mode_sel = 1 bring the machine to the reset state from any starting state.
- R5: wrap_ir_sel is 1 in the seven instruction-path states, from select-instruction through update-instruction. It is 0 in every other state.
- R6: wrap_shift_en is 1 only in the data-shift and instruction-shift states.
- R7: wrap_capture_en is 1 only in the data-capture and instruction-capture states.
- R8: wrap_update_en is 1 only in the data-update and instruction-update states.
- R9: wrap_rst_n is 0 exactly when the machine is in the reset state or test_rst_n is low. It is 1 otherwise.
- R10: At most one of wrap_shift_en, wrap_capture_en and wrap_update_en is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock; the state advances on its rising edge |
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| test_mode_sel | input | 1 | Mode-select line that chooses the next state |
| wrap_clk | output | 1 | Wrapper clock, a direct copy of test_clk |
| wrap_rst_n | output | 1 | Active-low wrapper reset |
| wrap_ir_sel | output | 1 | Selects the wrapper instruction register path |
| wrap_shift_en | output | 1 | Shift enable for the selected wrapper register |
| wrap_capture_en | output | 1 | Capture enable for the selected wrapper register |
| wrap_update_en | output | 1 | Update enable for the selected wrapper register |

## Verification
The clocked properties assume that test_mode_sel is stable around each rising edge of test_clk. They also assume that test_rst_n is asserted and released away from that edge, so that every state step is defined by a single sampled mode-select value. The stimulus meets both assumptions. It changes test_mode_sel only on falling edges, and it drops or releases the reset a fixed delay after a falling edge. The random mode-select stream is biased toward 0 so that the pause and shift loops are visited. Directed bursts of ones then start from whatever state the random walk reached.

// File: rtl/wcf_pkg.sv
`timescale 1ns/1ps
package wcf_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_D_SEL   = 4'd2,
    ST_D_CAP   = 4'd3,
    ST_D_SHIFT = 4'd4,
    ST_D_EXIT1 = 4'd5,
    ST_D_PAUSE = 4'd6,
    ST_D_EXIT2 = 4'd7,
    ST_D_UPD   = 4'd8,
    ST_I_SEL   = 4'd9,
    ST_I_CAP   = 4'd10,
    ST_I_SHIFT = 4'd11,
    ST_I_EXIT1 = 4'd12,
    ST_I_PAUSE = 4'd13,
    ST_I_EXIT2 = 4'd14,
    ST_I_UPD   = 4'd15
  } wcf_state_e;

  typedef struct packed {
    logic rst_n;
    logic ir_sel;
    logic shift_en;
    logic capture_en;
    logic update_en;
  } wcf_ctrl_t;
endpackage

// File: rtl/wcf_next_state.sv
`timescale 1ns/1ps
module wcf_next_state
  import wcf_pkg::*;
(
  input  wcf_state_e cur,
  input  logic       mode_sel,
  output wcf_state_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_RESET:   nxt = mode_sel ? ST_RESET   : ST_IDLE;
      ST_IDLE:    nxt = mode_sel ? ST_D_SEL   : ST_IDLE;
      ST_D_SEL:   nxt = mode_sel ? ST_I_SEL   : ST_D_CAP;
      ST_D_CAP:   nxt = mode_sel ? ST_D_EXIT1 : ST_D_SHIFT;
      ST_D_SHIFT: nxt = mode_sel ? ST_D_EXIT1 : ST_D_SHIFT;
      ST_D_EXIT1: nxt = mode_sel ? ST_D_UPD   : ST_D_PAUSE;
      ST_D_PAUSE: nxt = mode_sel ? ST_D_EXIT2 : ST_D_PAUSE;
      ST_D_EXIT2: nxt = mode_sel ? ST_D_UPD   : ST_D_SHIFT;
      ST_D_UPD:   nxt = mode_sel ? ST_D_SEL   : ST_IDLE;
      ST_I_SEL:   nxt = mode_sel ? ST_RESET   : ST_I_CAP;
      ST_I_CAP:   nxt = mode_sel ? ST_I_EXIT1 : ST_I_SHIFT;
      ST_I_SHIFT: nxt = mode_sel ? ST_I_EXIT1 : ST_I_SHIFT;
      ST_I_EXIT1: nxt = mode_sel ? ST_I_UPD   : ST_I_PAUSE;
      ST_I_PAUSE: nxt = mode_sel ? ST_I_EXIT2 : ST_I_PAUSE;
      ST_I_EXIT2: nxt = mode_sel ? ST_I_UPD   : ST_I_SHIFT;
      ST_I_UPD:   nxt = mode_sel ? ST_D_SEL   : ST_IDLE;
      default:    nxt = ST_RESET;
    endcase
  end
endmodule

// File: rtl/wcf_state_reg.sv
`timescale 1ns/1ps
module wcf_state_reg
  import wcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wcf_state_e nxt,
  output wcf_state_e cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_RESET;
    else        cur <= nxt;
  end
endmodule

// File: rtl/wcf_strobe_decode.sv
`timescale 1ns/1ps
module wcf_strobe_decode
  import wcf_pkg::*;
(
  input  wcf_state_e cur,
  input  logic       rst_n,
  output wcf_ctrl_t  ctrl
);
  logic in_ir_branch;

  always_comb begin
    unique case (cur)
      ST_I_SEL, ST_I_CAP, ST_I_SHIFT, ST_I_EXIT1,
      ST_I_PAUSE, ST_I_EXIT2, ST_I_UPD: in_ir_branch = 1'b1;
      default:                          in_ir_branch = 1'b0;
    endcase
  end

  always_comb begin
    ctrl            = '0;
    ctrl.rst_n      = rst_n && (cur != ST_RESET);
    ctrl.ir_sel     = rst_n && in_ir_branch;
    ctrl.shift_en   = rst_n && (cur == ST_D_SHIFT || cur == ST_I_SHIFT);
    ctrl.capture_en = rst_n && (cur == ST_D_CAP   || cur == ST_I_CAP);
    ctrl.update_en  = rst_n && (cur == ST_D_UPD   || cur == ST_I_UPD);
  end

  // R10: the three strobes never overlap
  always_comb begin
    if (rst_n === 1'b1)
      a_r10_strobe_exclusive: assert ($countones({ctrl.shift_en, ctrl.capture_en, ctrl.update_en}) <= 1);
  end
endmodule

// File: rtl/wrapper_ctrl_fsm.sv
`timescale 1ns/1ps
module wrapper_ctrl_fsm
  import wcf_pkg::*;
(
  input  logic test_clk,
  input  logic test_rst_n,
  input  logic test_mode_sel,
  output logic wrap_clk,
  output logic wrap_rst_n,
  output logic wrap_ir_sel,
  output logic wrap_shift_en,
  output logic wrap_capture_en,
  output logic wrap_update_en
);
  localparam int HOLD_LEN = 5;
  localparam int HOLD_W   = $clog2(HOLD_LEN + 1);

  wcf_state_e st_cur, st_nxt;
  wcf_ctrl_t  ctrl;

  wcf_next_state u_next (.cur(st_cur), .mode_sel(test_mode_sel), .nxt(st_nxt));
  wcf_state_reg  u_reg  (.clk(test_clk), .rst_n(test_rst_n), .nxt(st_nxt), .cur(st_cur));
  wcf_strobe_decode u_dec (.cur(st_cur), .rst_n(test_rst_n), .ctrl(ctrl));

  assign wrap_clk        = test_clk;
  assign wrap_rst_n      = ctrl.rst_n;
  assign wrap_ir_sel     = ctrl.ir_sel;
  assign wrap_shift_en   = ctrl.shift_en;
  assign wrap_capture_en = ctrl.capture_en;
  assign wrap_update_en  = ctrl.update_en;

  // Counts consecutive mode-select-high edges; used only by the property for R4.
  logic [HOLD_W-1:0] ones_run;
  always_ff @(posedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n)                      ones_run <= '0;
    else if (!test_mode_sel)              ones_run <= '0;
    else if (ones_run != HOLD_W'(HOLD_LEN)) ones_run <= ones_run + 1'b1;
  end

  a_r4_hold_reaches_reset: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (ones_run == HOLD_W'(HOLD_LEN)) |-> !wrap_rst_n);

  a_r7_capture_single: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    wrap_capture_en |=> !wrap_capture_en && !wrap_update_en);

  a_r8_update_leaves: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    wrap_update_en |=> !wrap_shift_en && !wrap_capture_en && !wrap_update_en && !wrap_ir_sel);

  a_r5_ir_entry: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    (wrap_ir_sel && !$past(wrap_ir_sel)) |-> $past(test_mode_sel));

  a_r9_reset_quiet: assert property (@(posedge test_clk) disable iff (!test_rst_n)
    !wrap_rst_n |-> !wrap_ir_sel && !wrap_shift_en && !wrap_capture_en && !wrap_update_en);

  // R1: asynchronous reset forces every output to its inactive level
  always_comb begin
    if (test_rst_n === 1'b0)
      a_r1_async_hold: assert (!wrap_rst_n && !wrap_ir_sel && !wrap_shift_en &&
                               !wrap_capture_en && !wrap_update_en);
  end
endmodule

// File: tb/wrapper_ctrl_fsm_test.sv
`timescale 1ns/1ps
module wrapper_ctrl_fsm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1;
  logic wclk, wrst_n, wir, wsh, wcap, wupd;
  int   nchk = 0;
  int   nbad = 0;
  int   mst  = 0;   // bench model state, 0..15 (own numbering)

  always #2 clk = ~clk;  // 250 MHz

  wrapper_ctrl_fsm uut (
    .test_clk(clk), .test_rst_n(rst_n), .test_mode_sel(tms),
    .wrap_clk(wclk), .wrap_rst_n(wrst_n), .wrap_ir_sel(wir),
    .wrap_shift_en(wsh), .wrap_capture_en(wcap), .wrap_update_en(wupd));

  // Model states: 0 reset,1 idle, data 2..8 (sel,cap,shift,ex1,pause,ex2,upd), instr 9..15 same order
  function automatic int step(int s, bit m);
    case (s)
      0: return m ? 0 : 1;
      1: return m ? 2 : 1;
      2: return m ? 9 : 3;
      9: return m ? 0 : 10;
      8, 15: return m ? 2 : 1;
      default: begin
        int b = (s >= 9) ? 9 : 2;
        case (s - b)
          1, 2: return m ? b + 3 : b + 2;
          3: return m ? b + 6 : b + 4;
          4: return m ? b + 5 : b + 4;
          5: return m ? b + 6 : b + 2;
          default: return 0;
        endcase
      end
    endcase
  endfunction

  function automatic logic [4:0] expect_out(int s, bit r);
    logic [4:0] e;
    if (!r) return 5'b00000;
    e[4] = (s != 0);
    e[3] = (s >= 9);
    e[2] = (s == 4) || (s == 11);
    e[1] = (s == 3) || (s == 10);
    e[0] = (s == 8) || (s == 15);
    return e;
  endfunction

  task automatic check(string ctx);
    logic [4:0] a, e;
    a = {wrst_n, wir, wsh, wcap, wupd};
    e = expect_out(mst, rst_n);
    nchk++;
    if (a !== e) begin
      nbad++;
      if (a[4] !== e[4]) $display("FAIL R9 %s wrap_rst_n act=%b exp=%b", ctx, a[4], e[4]);
      if (a[3] !== e[3]) $display("FAIL R5 %s wrap_ir_sel act=%b exp=%b", ctx, a[3], e[3]);
      if (a[2] !== e[2]) $display("FAIL R6 %s wrap_shift_en act=%b exp=%b", ctx, a[2], e[2]);
      if (a[1] !== e[1]) $display("FAIL R7 %s wrap_capture_en act=%b exp=%b", ctx, a[1], e[1]);
      if (a[0] !== e[0]) $display("FAIL R8 %s wrap_update_en act=%b exp=%b", ctx, a[0], e[0]);
    end
    if ((a[2] + a[1] + a[0]) > 1) begin
      nbad++;
      $display("FAIL R10 %s strobes act=%b exp=at most one", ctx, a[2:0]);
    end
  endtask

  task automatic clk_check(string ctx);
    nchk++;
    if (wclk !== clk) begin
      nbad++;
      $display("FAIL R2 %s wrap_clk act=%b exp=%b", ctx, wclk, clk);
    end
  endtask

  // Drive tms on the falling edge, step model on the rising edge, check 1 ns later.
  task automatic tick(bit m, string ctx);
    @(negedge clk);
    tms = m;
    #1 clk_check(ctx);
    @(posedge clk);
    mst = step(mst, m);
    #1 check(ctx);
    clk_check(ctx);
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int seed = 32'h5eed_1500;
    void'($urandom(seed));
    // R1: outputs held inactive under reset, across clock edges
    repeat (3) @(posedge clk);
    #1 check("R1 reset hold");
    @(negedge clk); tms = 0;
    @(posedge clk); #1 check("R1 reset ignores tms");
    @(negedge clk); #1 rst_n = 1'b1; mst = 0;
    check("R9 after release");

    // R3 directed: walk data branch then instruction branch
    tick(0, "R3 idle");
    tick(1, "R3 sel-d"); tick(0, "R3 cap-d"); tick(0, "R3 shift-d"); tick(0, "R3 shift-d2");
    tick(1, "R3 ex1-d"); tick(0, "R3 pause-d"); tick(1, "R3 ex2-d"); tick(0, "R3 shift-d3");
    tick(1, "R3 ex1-d2"); tick(1, "R3 upd-d"); tick(1, "R3 sel-d2"); tick(1, "R3 sel-i");
    tick(0, "R3 cap-i"); tick(1, "R3 ex1-i"); tick(0, "R3 pause-i"); tick(1, "R3 ex2-i");
    tick(1, "R3 upd-i"); tick(0, "R3 idle2");

    // R3 random walks, each followed by a five-ones burst (R4)
    for (int t = 0; t < 150; t++) begin
      int n = int'($urandom_range(1, 20));
      for (int k = 0; k < n; k++) tick(($urandom_range(0, 99) < 35), "R3 random");
      for (int k = 0; k < 5; k++) tick(1'b1, "R4 ones burst");
      nchk++;
      if (wrst_n !== 1'b0) begin
        nbad++;
        $display("FAIL R4 after five ones wrap_rst_n act=%b exp=0", wrst_n);
      end
      tick(1'b0, "R3 leave reset");
    end

    // R1: asynchronous reset mid-branch, away from the clock edge
    tick(1, "R1 prep"); tick(0, "R1 prep2"); tick(0, "R1 prep3");
    @(negedge clk); #1 rst_n = 1'b0; mst = 0;
    #0.5 check("R1 async assert");
    @(posedge clk); #1 check("R1 held");
    @(negedge clk); #1 rst_n = 1'b1;
    check("R9 released");
    tick(0, "R3 after async");

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule